// File: doc/BRIEF.md
# GPIO Port Register Block

This block gives software control over a 32-pin general-purpose I/O port through a small register bank. Each pin has one bit in every register. A data register holds the value driven onto the pins. A direction register chooses, for each pin, whether the block drives it. A read-only view returns the pin levels after they have been brought into the clock domain.

Three write-only command offsets change the output latch one bit at a time. One sets bits, one clears bits and one inverts bits. Only the bits written as 1 are affected. Software can therefore change a single pin without a read-modify-write sequence that another agent could interrupt.

Register accesses travel on a request channel and a response channel, each using a valid/ready handshake. Every request, read or write, produces exactly one response. The block holds one response at a time. While that response waits for the consumer, no new request is accepted. When the consumer takes the response in the same cycle that a new request arrives, both happen together, so full throughput is kept.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, `pin_out` is all zeros, `pin_oe` is all zeros, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A write to byte offset 0x00 loads the output latch with `req_wdata`. A read of 0x00 returns the latch, not the pin levels.
- R3: A write to offset 0x04 drives to 1 every latch bit whose written bit is 1 and leaves the other latch bits unchanged.
- R4: A write to offset 0x08 drives to 0 every latch bit whose written bit is 1 and leaves the other latch bits unchanged.
- R5: A write to offset 0x0C inverts every latch bit whose written bit is 1 and leaves the other latch bits unchanged.
- R6: A read of offset 0x10 returns `pin_in` after two synchronizing flops. A pin level present before clock edge k is returned by a read accepted at edge k+2 or later. A write to 0x10 changes neither `pin_out` nor `pin_oe`.
- R7: A write to offset 0x14 loads the direction register, where 1 means output and 0 means input. A read of 0x14 returns it. Each `pin_oe` bit equals its direction bit from the cycle after the write.
- R8: Reads of offsets 0x04, 0x08 and 0x0C return zero.
- R9: Any offset not listed above, including offsets that are not multiples of four, is unmapped. Writes to it change no state. Reads of it return zero.
- R10: A request is accepted in a cycle where both `req_valid` and `req_ready` are 1. `req_ready` is 1 exactly when no response is pending or `rsp_ready` is 1. A pending response keeps `rsp_valid` high and `rsp_rdata` stable until it is taken.
- R11: Each accepted request produces one response, with `rsp_valid` high in the cycle after acceptance. Responses to writes carry `rsp_rdata` of zero. Responses to reads carry the register value as it stood in the cycle of acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | A response is pending |
| rsp_ready | input | 1 | The consumer takes the pending response |
| rsp_rdata | output | 32 | Read data of the pending response |
| pin_in | input | 32 | Pin levels, asynchronous to `clk` |
| pin_out | output | 32 | Output latch driven to the pins |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the hand-off of a pending response and the acceptance of the next request. The bench holds `rsp_ready` low over several offered requests and then raises it while a request is still offered. It checks that `req_ready` follows the response slot and that the held data does not move.

The second pair is a read of the input view while the pins are changing. The bench changes `pin_in` every cycle during back-to-back reads. A behavioural model, with a two-entry history queue, predicts which pin sample each read must return.

Both cases, together with randomly mixed traffic, are compared against the model on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // register selected by a request offset
  typedef enum logic [2:0] {
    SEL_DATA = 3'd0,
    SEL_SET  = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_TGL  = 3'd3,
    SEL_PIN  = 3'd4,
    SEL_DIR  = 3'd5,
    SEL_NONE = 3'd6
  } reg_sel_e;

  localparam logic [15:0] OFS_DATA = 16'h0000;
  localparam logic [15:0] OFS_SET  = 16'h0004;
  localparam logic [15:0] OFS_CLR  = 16'h0008;
  localparam logic [15:0] OFS_TGL  = 16'h000C;
  localparam logic [15:0] OFS_PIN  = 16'h0010;
  localparam logic [15:0] OFS_DIR  = 16'h0014;

  function automatic reg_sel_e decode_offset(input logic [15:0] ofs);
    case (ofs)
      OFS_DATA: return SEL_DATA;
      OFS_SET:  return SEL_SET;
      OFS_CLR:  return SEL_CLR;
      OFS_TGL:  return SEL_TGL;
      OFS_PIN:  return SEL_PIN;
      OFS_DIR:  return SEL_DIR;
      default:  return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dir
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      dir  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA: dout <= wdata;
        SEL_SET:  dout <= dout | wdata;
        SEL_CLR:  dout <= dout & ~wdata;
        SEL_TGL:  dout <= dout ^ wdata;
        SEL_DIR:  dir  <= wdata;
        default:  ;
      endcase
    end
  end

  // R2
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DATA) |=> dout == $past(wdata));

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_SET) |=>
      ((dout & $past(wdata)) == $past(wdata)) &&
      ((dout & ~$past(wdata)) == ($past(dout) & ~$past(wdata))));

  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_CLR) |=>
      ((dout & $past(wdata)) == '0) &&
      ((dout & ~$past(wdata)) == ($past(dout) & ~$past(wdata))));

  // R5
  tgl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_TGL) |=> (dout ^ $past(dout)) == $past(wdata));

  // R5
  dir_kept_on_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_TGL) |=> $stable(dir));

endmodule

// File: rtl/gpio_rsp_slot.sv
module gpio_rsp_slot #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [WIDTH-1:0] rd_val,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_rdata,
  output logic             free
);

  assign free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));

  // R11
  rsp_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid && rsp_rdata == $past(rd_val));

  // R10
  no_take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> free);

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WIDTH-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WIDTH-1:0]  rsp_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  localparam int unsigned OFS_W = 16;

  reg_sel_e         sel;
  logic             slot_free;
  logic             accept;
  logic             wr_en;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dout;
  logic [WIDTH-1:0] dir;
  logic [WIDTH-1:0] rd_val;

  assign sel       = decode_offset(OFS_W'(req_addr));
  assign req_ready = slot_free;
  assign accept    = req_valid && slot_free;
  assign wr_en     = accept && req_write;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  gpio_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .sel   (sel),
    .wdata (req_wdata),
    .dout  (dout),
    .dir   (dir)
  );

  always_comb begin
    rd_val = '0;
    if (!req_write) begin
      case (sel)
        SEL_DATA: rd_val = dout;
        SEL_PIN:  rd_val = pin_sync;
        SEL_DIR:  rd_val = dir;
        default:  rd_val = '0;
      endcase
    end
  end

  gpio_rsp_slot #(.WIDTH(WIDTH)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (accept),
    .rd_val    (rd_val),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .free      (slot_free)
  );

  assign pin_out = dout;
  assign pin_oe  = dir;

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && sel == SEL_NONE) |=> $stable(pin_out) && $stable(pin_oe));

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && sel == SEL_NONE) |=> rsp_rdata == '0);

  // R6
  pin_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && sel == SEL_PIN) |=> $stable(pin_out) && $stable(pin_oe));

  // R8
  cmd_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && (sel == SEL_SET || sel == SEL_CLR || sel == SEL_TGL))
      |=> rsp_rdata == '0);

  // R7
  oe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && sel == SEL_DIR) |=> pin_oe == $past(req_wdata));

  // R11
  wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> rsp_valid && rsp_rdata == '0);

endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;
  localparam int W  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [W-1:0]  req_wdata;
  logic          rsp_valid, rsp_ready;
  logic [W-1:0]  rsp_rdata, pin_in, pin_out, pin_oe;

  always #5 clk = ~clk;

  gpio_port_regs u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string tag = "R1";
  logic [W-1:0] pins = '0;

  // reference model state
  logic [W-1:0] m_dout = '0, m_dir = '0, m_rdata = '0;
  bit m_rvalid = 0;
  logic [W-1:0] sync_q[$];

  task automatic chk(input bit ok, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      8'h00:   return m_dout;
      8'h10:   return sync_q[0];
      8'h14:   return m_dir;
      default: return '0;
    endcase
  endfunction

  // one clock: drive at negedge, predict, compare at next negedge
  task automatic cyc(input bit v, input bit w, input logic [AW-1:0] a,
                     input logic [W-1:0] d, input bit rr);
    bit rdy;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    rsp_ready = rr; pin_in = pins;
    #1;
    rdy = !m_rvalid || rr;
    chk(req_ready == rdy, "req_ready (R10)", W'(req_ready), W'(rdy));
    if (v && rdy) begin
      m_rvalid = 1;
      m_rdata = w ? '0 : model_read(a);
      if (w) begin
        case (a)
          8'h00: m_dout = d;
          8'h04: m_dout = m_dout | d;
          8'h08: m_dout = m_dout & ~d;
          8'h0C: m_dout = m_dout ^ d;
          8'h14: m_dir = d;
          default: ;
        endcase
      end
    end else if (rr) begin
      m_rvalid = 0;
    end
    void'(sync_q.pop_front());
    sync_q.push_back(pins);
    @(negedge clk);
    chk(rsp_valid == m_rvalid, "rsp_valid (R11)", W'(rsp_valid), W'(m_rvalid));
    if (m_rvalid) chk(rsp_rdata == m_rdata, "rsp_rdata", rsp_rdata, m_rdata);
    chk(pin_out == m_dout, "pin_out", pin_out, m_dout);
    chk(pin_oe == m_dir, "pin_oe (R7)", pin_oe, m_dir);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    cyc(1, 1, a, d, 1);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    cyc(1, 0, a, '0, 1);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    rsp_ready = 1; pin_in = '0;
    sync_q.push_back('0); sync_q.push_back('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    tag = "R1";
    chk(pin_out == '0, "reset pin_out", pin_out, '0);
    chk(pin_oe == '0, "reset pin_oe", pin_oe, '0);
    chk(rsp_valid == 1'b0, "reset rsp_valid", W'(rsp_valid), '0);
    chk(req_ready == 1'b1, "reset req_ready", W'(req_ready), 1);

    tag = "R2";
    wr(8'h00, 32'hA5A5_F00F); rd(8'h00); cyc(0, 0, 0, 0, 1);
    tag = "R7";
    wr(8'h14, 32'hFFFF_0000); rd(8'h14);
    tag = "R3";
    wr(8'h04, 32'h0000_00FF); rd(8'h00);
    tag = "R4";
    wr(8'h08, 32'hF000_000F); rd(8'h00);
    tag = "R5";
    wr(8'h0C, 32'hFFFF_0000); rd(8'h00); wr(8'h0C, 32'hFFFF_0000); rd(8'h00);
    tag = "R8";
    rd(8'h04); rd(8'h08); rd(8'h0C);

    tag = "R6";
    for (int i = 0; i < 10; i++) begin
      pins = $urandom;
      rd(8'h10);
    end
    rd(8'h10); rd(8'h10); rd(8'h10);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h00); rd(8'h14); rd(8'h10);

    tag = "R9";
    wr(8'h18, 32'h1234_5678); wr(8'h01, 32'hFFFF_FFFF); wr(8'hFC, 32'h0F0F_0F0F);
    rd(8'h18); rd(8'h01); rd(8'h00); rd(8'h14);

    tag = "R10";
    cyc(1, 0, 8'h00, 0, 0);
    for (int i = 0; i < 4; i++) cyc(1, 1, 8'h00, 32'h0000_1111, 0);
    cyc(1, 1, 8'h00, 32'h0000_2222, 1);
    cyc(1, 0, 8'h00, 0, 1);
    cyc(1, 1, 8'h04, 32'h8000_0000, 0);
    cyc(0, 0, 8'h00, 0, 0);
    cyc(1, 0, 8'h00, 0, 1);
    cyc(0, 0, 8'h00, 0, 1);

    tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      case ($urandom_range(0, 7))
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
        4: a = 8'h10; 5: a = 8'h14; 6: a = 8'h18; default: a = 8'h03;
      endcase
      if ($urandom_range(0, 3) == 0) pins = $urandom;
      cyc(($urandom_range(0, 3) != 0), $urandom_range(0, 1), a, $urandom,
          ($urandom_range(0, 3) != 0));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog %s: actual=%0d expected=%0d", tag, 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule